// File: doc/BRIEF.md
# Profiled RAM Address Ramp Sequencer

This block produces the read addresses that step a waveform RAM through a one-shot playback for a synthesizer datapath. A table of eight profiles is presented on flat configuration buses. Each profile holds a first address, a last address, a step interval and a return-to-start flag. A 3-bit select input picks the active profile. Any of the select pins may be used alone to flip between two profiles, or any two of them to choose among four.

A playback begins when the update strobe is high, or when the select value differs from the value it had on the previous clock. The block loads the first address of the selected profile, clears its completion flag and raises its read enable. From then on it advances the address by one each time its interval timer expires. At the last address it either stops there, or waits one more interval and jumps back to the first address, as the profile's return-to-start flag decides. In both cases it then halts with the completion flag high. A new profile selection abandons a playback in progress at once. The profile fields are captured when a playback begins, so a table rewrite takes effect at the next playback.

Top module: `ramp_addr_seq`

## Requirements
- R1: With the update strobe high at a clock edge, the next cycle shows the selected profile's first address on `addr_o`, with `done_o` = 0 and `rd_en_o` = 1. This also applies while a playback is halted.
- R2: A select value that differs from the previous cycle's select value restarts the playback, even mid-sweep. The restart timing is that of R1 and uses the newly selected profile. Changing a single select bit is enough.
- R3: While playing, the address increments by exactly one every M cycles, where M is the profile's interval field. The first step comes M cycles after the load. An interval of 0 behaves as 1.
- R4: With the return-to-start flag at 0, the step that reaches the last address also sets `done_o` = 1 and `rd_en_o` = 0, and the address stays at the last address.
- R5: With the return-to-start flag at 1, the address holds the last address for M cycles with `done_o` = 0. It then returns to the first address, with `done_o` = 1 and `rd_en_o` = 0.
- R6: If the first address is greater than or equal to the last address, the first address is shown for one cycle with `rd_en_o` = 1. The next cycle shows `done_o` = 1 and `rd_en_o` = 0, and the address stays unchanged.
- R7: Once halted, `addr_o`, `done_o` = 1 and `rd_en_o` = 0 stay unchanged until the next restart. `done_o` and `rd_en_o` are never high together.
- R8: In reset and afterwards, until the first restart, `addr_o` = 0, `done_o` = 0 and `rd_en_o` = 0.
- R9: The profile fields are captured at the restart. Changes to the configuration buses during a playback do not alter that playback.
- R10: Profile p uses bits [p*10 +: 10] of `cfg_first_i` and `cfg_last_i`, bits [p*16 +: 16] of `cfg_rate_i`, and bit p of `cfg_ret_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe, restarts playback |
| sel_i | input | 3 | Profile select |
| cfg_first_i | input | 80 | First address of each profile |
| cfg_last_i | input | 80 | Last address of each profile |
| cfg_rate_i | input | 128 | Step interval in cycles of each profile |
| cfg_ret_i | input | 8 | Return-to-start flag of each profile |
| addr_o | output | 10 | RAM read address |
| rd_en_o | output | 1 | High while a playback is stepping |
| done_o | output | 1 | Playback complete |

## Verification
The bench targets the interval boundary. A timer off by one would show the first step one cycle early or late, and a zero interval that is not promoted to 1 would stall or wrap the counter. It drives both empty-range cases (first equal to last, and first above last). A design that compared them wrongly would run past the last address through the whole address space. It switches profiles mid-sweep with a single select bit and rewrites a profile's fields during its own playback. A design that polls the table live would then finish at the wrong address or pace. The return-to-start path is checked for its extra interval at the last address, which a design that jumps back at once would skip.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PLAY = 2'd1,
        SEQ_HALT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic play;
        logic fin;
    } seq_flags_t;

    localparam int unsigned DEF_ADDR_W = 10;
    localparam int unsigned DEF_RATE_W = 16;
    localparam int unsigned DEF_SEL_W  = 3;

endpackage

// File: rtl/ramp_prof_mux.sv
module ramp_prof_mux #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned RATE_W = 16,
    parameter int unsigned SEL_W  = 3,
    localparam int unsigned NPROF = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]        sel_i,
    input  logic [NPROF*ADDR_W-1:0] first_flat_i,
    input  logic [NPROF*ADDR_W-1:0] last_flat_i,
    input  logic [NPROF*RATE_W-1:0] rate_flat_i,
    input  logic [NPROF-1:0]        ret_flat_i,
    output logic [ADDR_W-1:0]       first_o,
    output logic [ADDR_W-1:0]       last_o,
    output logic [RATE_W-1:0]       rate_o,
    output logic                    ret_o
);
    logic [ADDR_W-1:0] first_arr [NPROF];
    logic [ADDR_W-1:0] last_arr  [NPROF];
    logic [RATE_W-1:0] rate_arr  [NPROF];

    // R10: fixed per-profile field slicing
    for (genvar p = 0; p < NPROF; p++) begin : g_slice
        assign first_arr[p] = first_flat_i[p*ADDR_W +: ADDR_W];
        assign last_arr[p]  = last_flat_i[p*ADDR_W +: ADDR_W];
        assign rate_arr[p]  = rate_flat_i[p*RATE_W +: RATE_W];
    end

    assign first_o = first_arr[sel_i];
    assign last_o  = last_arr[sel_i];
    assign rate_o  = rate_arr[sel_i];
    assign ret_o   = ret_flat_i[sel_i];
endmodule

// File: rtl/ramp_restart.sv
module ramp_restart #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             restart_o
);
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= sel_i;
    end

    // R1/R2: strobe or any change of the select word
    assign restart_o = upd_i | (sel_i != sel_q);
endmodule

// File: rtl/ramp_rate_timer.sv
module ramp_rate_timer #(
    parameter int unsigned RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [RATE_W-1:0] period_i,
    input  logic              en_i,
    output logic              expire_o
);
    logic [RATE_W-1:0] period_q;
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] period_eff;

    // R3: an interval of zero counts as one
    assign period_eff = (period_i == '0) ? RATE_W'(1) : period_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= RATE_W'(1);
            cnt_q    <= '0;
        end else if (load_i) begin
            period_q <= period_eff;
            cnt_q    <= period_eff - RATE_W'(1);
        end else if (en_i) begin
            if (cnt_q == '0) cnt_q <= period_q - RATE_W'(1);
            else             cnt_q <= cnt_q - RATE_W'(1);
        end
    end

    assign expire_o = en_i & ~load_i & (cnt_q == '0);
endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper
    import ramp_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic [ADDR_W-1:0] first_i,
    input  logic [ADDR_W-1:0] last_i,
    input  logic              ret_i,
    input  logic              expire_i,
    output logic [ADDR_W-1:0] addr_o,
    output seq_flags_t        flags_o
);
    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] first_q;
    logic [ADDR_W-1:0] last_q;
    logic              ret_q;
    logic              empty_q;
    logic              fin_q;
    logic [ADDR_W-1:0] addr_nxt;

    assign addr_nxt = addr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            first_q <= '0;
            last_q  <= '0;
            ret_q   <= 1'b0;
            empty_q <= 1'b0;
            fin_q   <= 1'b0;
        end else if (restart_i) begin
            // R1/R2/R9: capture the selected profile and reload
            state_q <= SEQ_PLAY;
            addr_q  <= first_i;
            first_q <= first_i;
            last_q  <= last_i;
            ret_q   <= ret_i;
            empty_q <= (first_i >= last_i);
            fin_q   <= 1'b0;
        end else if (state_q == SEQ_PLAY) begin
            if (empty_q) begin
                // R6: empty range ends one cycle after the load
                state_q <= SEQ_HALT;
                fin_q   <= 1'b1;
            end else if (expire_i) begin
                if (addr_q == last_q) begin
                    // R5: return to the first address after the dwell
                    addr_q  <= first_q;
                    state_q <= SEQ_HALT;
                    fin_q   <= 1'b1;
                end else begin
                    addr_q <= addr_nxt;
                    if ((addr_nxt == last_q) && !ret_q) begin
                        // R4: stop on the last address
                        state_q <= SEQ_HALT;
                        fin_q   <= 1'b1;
                    end
                end
            end
        end
    end

    assign addr_o       = addr_q;
    assign flags_o.play = (state_q == SEQ_PLAY);
    assign flags_o.fin  = fin_q;
endmodule

// File: rtl/ramp_addr_seq.sv
module ramp_addr_seq
    import ramp_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned RATE_W = DEF_RATE_W,
    parameter int unsigned SEL_W  = DEF_SEL_W,
    localparam int unsigned NPROF = 1 << SEL_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_i,
    input  logic [SEL_W-1:0]        sel_i,
    input  logic [NPROF*ADDR_W-1:0] cfg_first_i,
    input  logic [NPROF*ADDR_W-1:0] cfg_last_i,
    input  logic [NPROF*RATE_W-1:0] cfg_rate_i,
    input  logic [NPROF-1:0]        cfg_ret_i,
    output logic [ADDR_W-1:0]       addr_o,
    output logic                    rd_en_o,
    output logic                    done_o
);
    logic              restart;
    logic              expire;
    logic [ADDR_W-1:0] sel_first;
    logic [ADDR_W-1:0] sel_last;
    logic [RATE_W-1:0] sel_rate;
    logic              sel_ret;
    seq_flags_t        flags;

    ramp_restart #(.SEL_W(SEL_W)) u_restart (
        .clk       (clk),
        .rst       (rst),
        .upd_i     (upd_i),
        .sel_i     (sel_i),
        .restart_o (restart)
    );

    ramp_prof_mux #(.ADDR_W(ADDR_W), .RATE_W(RATE_W), .SEL_W(SEL_W)) u_mux (
        .sel_i        (sel_i),
        .first_flat_i (cfg_first_i),
        .last_flat_i  (cfg_last_i),
        .rate_flat_i  (cfg_rate_i),
        .ret_flat_i   (cfg_ret_i),
        .first_o      (sel_first),
        .last_o       (sel_last),
        .rate_o       (sel_rate),
        .ret_o        (sel_ret)
    );

    ramp_rate_timer #(.RATE_W(RATE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (restart),
        .period_i (sel_rate),
        .en_i     (flags.play),
        .expire_o (expire)
    );

    ramp_stepper #(.ADDR_W(ADDR_W)) u_step (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .first_i   (sel_first),
        .last_i    (sel_last),
        .ret_i     (sel_ret),
        .expire_i  (expire),
        .addr_o    (addr_o),
        .flags_o   (flags)
    );

    assign rd_en_o = flags.play;
    assign done_o  = flags.fin;
endmodule

// File: rtl/ramp_addr_seq_chk.sv
module ramp_addr_seq_chk #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned RATE_W = 16,
    parameter int unsigned SEL_W  = 3,
    localparam int unsigned NPROF = 1 << SEL_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    upd_i,
    input logic [SEL_W-1:0]        sel_i,
    input logic [NPROF*ADDR_W-1:0] cfg_first_i,
    input logic [NPROF*RATE_W-1:0] cfg_rate_i,
    input logic [ADDR_W-1:0]       addr_o,
    input logic                    rd_en_o,
    input logic                    done_o
);
    logic [SEL_W-1:0]  sel_prev;
    logic              rs_c;
    logic [ADDR_W-1:0] first_sel;

    always_ff @(posedge clk) begin
        if (rst) sel_prev <= '0;
        else     sel_prev <= sel_i;
    end

    assign rs_c      = upd_i | (sel_i != sel_prev);
    assign first_sel = cfg_first_i[sel_i*ADDR_W +: ADDR_W];

    assert_restart_load_R1: assert property (@(posedge clk) disable iff (rst)
        rs_c |=> (addr_o == $past(first_sel)) && !done_o && rd_en_o);

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en_o && !rs_c) |=> (addr_o == $past(addr_o))
            || (addr_o == ADDR_W'($past(addr_o) + 1'b1)) || done_o);

    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !rd_en_o && !rs_c) |=> $stable(addr_o) && done_o && !rd_en_o);

    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !rd_en_o);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !rd_en_o && !rs_c) |=> !done_o && !rd_en_o && $stable(addr_o));
endmodule

bind ramp_addr_seq ramp_addr_seq_chk #(
    .ADDR_W(ADDR_W), .RATE_W(RATE_W), .SEL_W(SEL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .upd_i       (upd_i),
    .sel_i       (sel_i),
    .cfg_first_i (cfg_first_i),
    .cfg_rate_i  (cfg_rate_i),
    .addr_o      (addr_o),
    .rd_en_o     (rd_en_o),
    .done_o      (done_o)
);

// File: tb/ramp_addr_seq_bench.sv
`timescale 1ns/1ps
module ramp_addr_seq_bench;
    localparam int AW = 10;
    localparam int RW = 16;
    localparam int NP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd = 1'b0;
    logic [2:0] sel = 3'd0;
    logic [NP*AW-1:0] cfg_first, cfg_last;
    logic [NP*RW-1:0] cfg_rate;
    logic [NP-1:0]    cfg_ret;
    logic [AW-1:0] addr;
    logic rd_en, done;

    int p_first [NP];
    int p_last  [NP];
    int p_rate  [NP];
    bit p_ret   [NP];

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    // R10: profile p lives in its own slice of each bus
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            cfg_first[p*AW +: AW] = AW'(p_first[p]);
            cfg_last[p*AW +: AW]  = AW'(p_last[p]);
            cfg_rate[p*RW +: RW]  = RW'(p_rate[p]);
            cfg_ret[p]            = p_ret[p];
        end
    end

    ramp_addr_seq u_ramp_addr_seq (
        .clk(clk), .rst(rst), .upd_i(upd), .sel_i(sel),
        .cfg_first_i(cfg_first), .cfg_last_i(cfg_last),
        .cfg_rate_i(cfg_rate), .cfg_ret_i(cfg_ret),
        .addr_o(addr), .rd_en_o(rd_en), .done_o(done)
    );

    // behavioural reference model
    int m_addr, m_prev, m_wait, m_first, m_last, m_per;
    bit m_done, m_play, m_ret, m_empty;
    string m_tag = "R8";

    always @(posedge clk) begin
        if (rst) begin
            m_addr = 0; m_done = 0; m_play = 0; m_prev = 0; m_tag = "R8";
        end else begin
            bit rs;
            rs = upd || (int'(sel) != m_prev);
            m_prev = int'(sel);
            if (rs) begin
                m_first = p_first[sel]; m_last = p_last[sel];
                m_per   = (p_rate[sel] == 0) ? 1 : p_rate[sel];
                m_ret   = p_ret[sel];
                m_empty = (m_first >= m_last);
                m_addr = m_first; m_done = 0; m_play = 1; m_wait = m_per;
                m_tag = upd ? "R1" : "R2";
            end else if (m_play) begin
                if (m_empty) begin
                    m_done = 1; m_play = 0; m_tag = "R6";
                end else begin
                    m_wait--;
                    m_tag = "R3";
                    if (m_wait == 0) begin
                        m_wait = m_per;
                        if (m_addr == m_last) begin
                            m_addr = m_first; m_done = 1; m_play = 0; m_tag = "R5";
                        end else begin
                            m_addr++;
                            if (m_addr == m_last && !m_ret) begin
                                m_done = 1; m_play = 0; m_tag = "R4";
                            end
                        end
                    end
                end
            end else if (m_done) begin
                m_tag = "R7";
            end
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            n_chk++;
            if (int'(addr) != m_addr || rd_en != m_play || done != m_done) begin
                n_fail++;
                $display("FAIL %s model: addr/rd_en/done actual %0d/%0b/%0b expected %0d/%0b/%0b",
                         m_tag, addr, rd_en, done, m_addr, m_play, m_done);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_upd();
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic pick(input int s);
        sel = 3'(s);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        p_first = '{5, 20, 100, 50, 70, 0, 200, 300};
        p_last  = '{9, 23, 102, 50, 60, 1000, 210, 305};
        p_rate  = '{3, 1, 0, 4, 2, 2, 2, 1};
        p_ret   = '{0, 1, 0, 0, 1, 0, 0, 0};
        cyc(3);
        chk("R8 reset addr", addr, 0);
        chk("R8 reset rd_en", rd_en, 0);
        rst = 1'b0;
        cyc(3);
        chk("R8 idle done", done, 0);
        chk("R8 idle rd_en", rd_en, 0);

        // profile 0: first 5, last 9, interval 3, stop at last
        @(negedge clk);
        pulse_upd();
        chk("R1 load addr", addr, 5);
        chk("R1 load rd_en", rd_en, 1);
        cyc(2);
        chk("R3 before first step", addr, 5);
        cyc(1);
        chk("R3 first step", addr, 6);
        cyc(9);
        chk("R4 last addr", addr, 9);
        chk("R4 done", done, 1);
        chk("R4 rd_en low", rd_en, 0);
        cyc(10);
        chk("R7 hold addr", addr, 9);
        chk("R7 hold done", done, 1);
        pulse_upd();
        chk("R1 restart from halt", addr, 5);
        chk("R1 done cleared", done, 0);

        // profile 1: 20..23, interval 1, return to first
        pick(1);
        chk("R2 change loads profile 1", addr, 20);
        cyc(3);
        chk("R5 at last", addr, 23);
        chk("R5 not done yet", done, 0);
        cyc(1);
        chk("R5 back to first", addr, 20);
        chk("R5 done", done, 1);

        // profile 2: interval 0 acts as 1
        pick(2);
        chk("R2 profile 2 load", addr, 100);
        cyc(1);
        chk("R3 zero interval", addr, 101);
        cyc(1);
        chk("R4 profile 2 done", done, 1);

        // profile 3: first == last
        pick(3);
        chk("R6 equal load", addr, 50);
        chk("R6 equal rd_en", rd_en, 1);
        cyc(1);
        chk("R6 equal done", done, 1);
        chk("R6 equal addr", addr, 50);

        // profile 4: first > last
        pick(4);
        cyc(1);
        chk("R6 inverted done", done, 1);
        chk("R6 inverted addr", addr, 70);

        // profile 5 aborted by single-bit change to profile 7
        pick(5);
        cyc(10);
        chk("R3 long sweep progress", addr, 5);
        pick(7);
        chk("R2 abort load", addr, 300);
        chk("R2 abort done", done, 0);
        cyc(5);
        chk("R4 profile 7 end", addr, 305);

        // profile 6: table rewritten during playback
        pick(6);
        p_last[6] = 202;
        p_rate[6] = 1;
        cyc(19);
        chk("R9 old pace", addr, 209);
        cyc(1);
        chk("R9 old last", addr, 210);
        chk("R9 done", done, 1);
        pulse_upd();
        cyc(2);
        chk("R9 new table used", addr, 202);
        chk("R10 new table done", done, 1);

        // simultaneous strobe and select change
        upd = 1'b1; sel = 3'd0;
        @(negedge clk);
        upd = 1'b0;
        chk("R1 strobe with change", addr, 5);
        cyc(15);

        finished = 1;
        summary();
        $finish;
    end
endmodule